// File: doc/BRIEF.md
# Multiplexed-Bus Dual-Port Byte Memory

This block is a byte-wide memory that two independent masters share. Each master reaches it through its own port. A port has one bus that carries the address first and the data later, plus three active-low strobes: select, write strobe and read strobe. All of these arrive asynchronously to the block. The block runs from one fast system clock. It synchronizes every port input, finds the edges of the strobes, and drives each port through a small cycle state machine.

A master starts an access by putting an address on its bus and pulling select low. The block latches the address on that falling edge, so the master can then reuse the bus for data or leave it floating. Pulling the read strobe low makes the block drive the addressed byte through a separate output-enable signal that models the bus driver. Pulling the write strobe low lets the block sample the data. The byte is committed when the first of select or write strobe rises.

Both ports see the whole address space. Reads never need arbitration. When writes collide, the conflict is resolved in a fixed and documented way.

Top module: `mux_dpram`

## Requirements
- R1: The memory holds 2^ADDR_W bytes (256 by default), and either port can write and read every location, including addresses 0 and 255.
- R2: A port latches the bus value as its address on the falling edge of its select. Later bus values do not change the selected location while select stays low.
- R3: While select and read strobe are both low and the write strobe is high, the port asserts its bus output enable and presents the addressed byte. SYNC_STAGES+1 clock edges after each strobe change, the output enable follows the strobes. Otherwise it stays low.
- R4: A read ends at the first rise of select or read strobe. After that the port does not drive again until select rises and falls again, even if the read strobe is lowered once more.
- R5: The byte a port sampled while select and write strobe were low is written to the latched address once, when the first of select or write strobe rises.
- R6: Both ports can read the same location at the same time, and both present the stored byte.
- R7: When both ports commit a write to the same address on the same clock edge, port A's byte is kept (A_WRITE_WINS=1).
- R8: When one port commits a write while the other port reads the same address, the reading port presents the old byte in the cycle after the commit edge and the new byte from the next cycle on. The commit edge is the (SYNC_STAGES+1)-th clock edge after the terminating strobe change.
- R9: If the write and read strobes are seen low together while select is low, the port raises its error flag. It then neither drives nor writes until select rises.
- R10: After reset, both ports are idle, both bus output enables are low and both error flags are low. Memory contents are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_bus_i | input | ADDR_W | Port A shared bus, inbound (address, then write data) |
| a_ce_n | input | 1 | Port A select, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A read strobe, active low |
| a_bus_o | output | ADDR_W | Port A read data, zero when not driving |
| a_bus_oe | output | 1 | Port A bus driver enable |
| a_err | output | 1 | Port A protocol error flag |
| b_bus_i | input | ADDR_W | Port B shared bus, inbound |
| b_ce_n | input | 1 | Port B select, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B read strobe, active low |
| b_bus_o | output | ADDR_W | Port B read data, zero when not driving |
| b_bus_oe | output | 1 | Port B bus driver enable |
| b_err | output | 1 | Port B protocol error flag |

## Verification
On every clock, the bound checkers verify the following for each port: the driver is enabled only after the synchronized strobes requested a read, it releases one cycle after a terminating rise, and the latched address does not move while the port drives. They also verify that a commit lasts a single cycle and that the error flag is entered only from simultaneous write and read strobes and held until select rises. Only the bench scenarios can show the memory contents: which byte ends up stored after colliding writes, the exact cycle in which a concurrent reader sees the new byte, and that an erroneous cycle or a late bus change leaves the stored data untouched.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_READ,
      ST_WRITE,
      ST_DONE,
      ST_ERR
   } port_st_t;
endpackage

// File: rtl/mdp_sync.sv
module mdp_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= RST_VAL;
            else        stage_q[0] <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mdp_port_ctrl.sv
module mdp_port_ctrl
   import mdp_pkg::*;
#(
   parameter int AW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_i,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic          oe_n,
   output logic          ce_s,
   output logic          we_s,
   output logic          oe_s,
   output logic [AW-1:0] addr,
   output logic [AW-1:0] wdata,
   output logic          wr_en,
   output logic          drive,
   output logic          err
);
   localparam int W = AW + 3;
   localparam logic [W-1:0] IDLE_VAL = {3'b111, {AW{1'b0}}};

   logic [W-1:0]  raw_in, syn_in;
   logic [AW-1:0] bus_s;
   logic          ce_q, ce_fall;
   port_st_t      st_q, st_d;
   logic          ld_addr, cap_data, commit;
   logic [AW-1:0] addr_q, wdata_q;

   assign raw_in = {ce_n, we_n, oe_n, bus_i};

   mdp_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_VAL)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign ce_s  = syn_in[W-1];
   assign we_s  = syn_in[W-2];
   assign oe_s  = syn_in[W-3];
   assign bus_s = syn_in[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce_q <= 1'b1;
      else        ce_q <= ce_s;
   end
   assign ce_fall = ce_q & ~ce_s;

   always_comb begin
      st_d     = st_q;
      ld_addr  = 1'b0;
      cap_data = 1'b0;
      commit   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (ce_fall) begin
               st_d    = ST_SEL;
               ld_addr = 1'b1;
            end
         end
         ST_SEL: begin
            if (ce_s)                st_d = ST_IDLE;
            else if (!we_s && !oe_s) st_d = ST_ERR;
            else if (!oe_s)          st_d = ST_READ;
            else if (!we_s) begin
               st_d     = ST_WRITE;
               cap_data = 1'b1;
            end
         end
         ST_READ: begin
            if (ce_s)       st_d = ST_IDLE;
            else if (oe_s)  st_d = ST_DONE;
            else if (!we_s) st_d = ST_ERR;
         end
         ST_WRITE: begin
            if (ce_s || we_s) begin
               commit = 1'b1;
               st_d   = ce_s ? ST_IDLE : ST_DONE;
            end else if (!oe_s) begin
               st_d = ST_ERR;
            end else begin
               cap_data = 1'b1;
            end
         end
         ST_DONE, ST_ERR: begin
            if (ce_s) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         st_q <= st_d;
         if (ld_addr)  addr_q  <= bus_s;
         if (cap_data) wdata_q <= bus_s;
      end
   end

   assign addr  = addr_q;
   assign wdata = wdata_q;
   assign wr_en = commit;
   assign drive = (st_q == ST_READ);
   assign err   = (st_q == ST_ERR);
endmodule

// File: rtl/mdp_store.sv
module mdp_store #(
   parameter int AW           = 8,
   parameter int DW           = 8,
   parameter bit A_WRITE_WINS = 1'b1
) (
   input  logic          clk,
   input  logic          a_wr,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_wdata,
   output logic [DW-1:0] a_rdata,
   input  logic          b_wr,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_wdata,
   output logic [DW-1:0] b_rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   generate
      if (A_WRITE_WINS) begin : g_a_last
         always_ff @(posedge clk) begin
            if (b_wr) mem[b_addr] <= b_wdata;
            if (a_wr) mem[a_addr] <= a_wdata;
         end
      end else begin : g_b_last
         always_ff @(posedge clk) begin
            if (a_wr) mem[a_addr] <= a_wdata;
            if (b_wr) mem[b_addr] <= b_wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      a_rdata <= mem[a_addr];
      b_rdata <= mem[b_addr];
   end
endmodule

// File: rtl/mux_dpram.sv
module mux_dpram #(
   parameter int ADDR_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter bit A_WRITE_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] a_bus_i,
   input  logic              a_ce_n,
   input  logic              a_we_n,
   input  logic              a_oe_n,
   output logic [ADDR_W-1:0] a_bus_o,
   output logic              a_bus_oe,
   output logic              a_err,
   input  logic [ADDR_W-1:0] b_bus_i,
   input  logic              b_ce_n,
   input  logic              b_we_n,
   input  logic              b_oe_n,
   output logic [ADDR_W-1:0] b_bus_o,
   output logic              b_bus_oe,
   output logic              b_err
);
   localparam int DATA_W = ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_width
         $error("mux_dpram: ADDR_W must lie in 1..12");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("mux_dpram: SYNC_STAGES must lie in 1..4");
      end
   endgenerate

   logic              a_ce_s, a_we_s, a_oe_s, a_wr, a_drive;
   logic              b_ce_s, b_we_s, b_oe_s, b_wr, b_drive;
   logic [ADDR_W-1:0] a_addr, b_addr;
   logic [DATA_W-1:0] a_wdata, b_wdata, a_rdata, b_rdata;

   mdp_port_ctrl #(.AW(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_port_a (
      .clk (clk), .rst_n (rst_n), .bus_i (a_bus_i),
      .ce_n (a_ce_n), .we_n (a_we_n), .oe_n (a_oe_n),
      .ce_s (a_ce_s), .we_s (a_we_s), .oe_s (a_oe_s),
      .addr (a_addr), .wdata (a_wdata), .wr_en (a_wr),
      .drive (a_drive), .err (a_err)
   );

   mdp_port_ctrl #(.AW(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_port_b (
      .clk (clk), .rst_n (rst_n), .bus_i (b_bus_i),
      .ce_n (b_ce_n), .we_n (b_we_n), .oe_n (b_oe_n),
      .ce_s (b_ce_s), .we_s (b_we_s), .oe_s (b_oe_s),
      .addr (b_addr), .wdata (b_wdata), .wr_en (b_wr),
      .drive (b_drive), .err (b_err)
   );

   mdp_store #(.AW(ADDR_W), .DW(DATA_W), .A_WRITE_WINS(A_WRITE_WINS)) u_store (
      .clk (clk),
      .a_wr (a_wr), .a_addr (a_addr), .a_wdata (a_wdata), .a_rdata (a_rdata),
      .b_wr (b_wr), .b_addr (b_addr), .b_wdata (b_wdata), .b_rdata (b_rdata)
   );

   assign a_bus_oe = a_drive;
   assign b_bus_oe = b_drive;
   assign a_bus_o  = a_drive ? a_rdata : '0;
   assign b_bus_o  = b_drive ? b_rdata : '0;
endmodule

// File: rtl/mdp_port_chk.sv
module mdp_port_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ce_s,
   input logic          we_s,
   input logic          oe_s,
   input logic          drive,
   input logic          err,
   input logic          wr_en,
   input logic [AW-1:0] addr
);
   // R3: driving only follows a requested read
   p_drive_needs_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> $past(!ce_s && !oe_s && we_s));

   // R4: a terminating rise releases the driver on the next cycle
   p_release_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (drive && (ce_s || oe_s)) |=> !drive);

   // R2: latched address holds while the port drives
   p_addr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (drive && $past(drive)) |-> $stable(addr));

   // R5: one commit per write cycle
   p_single_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R9: error entered only from both strobes low under select
   p_err_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past(!ce_s && !we_s && !oe_s));

   // R9: error holds until select rises
   p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !ce_s) |=> err);
endmodule

bind mux_dpram mdp_port_chk #(.AW(ADDR_W)) u_chk_a (
   .clk (clk), .rst_n (rst_n), .ce_s (a_ce_s), .we_s (a_we_s), .oe_s (a_oe_s),
   .drive (a_drive), .err (a_err), .wr_en (a_wr), .addr (a_addr)
);

bind mux_dpram mdp_port_chk #(.AW(ADDR_W)) u_chk_b (
   .clk (clk), .rst_n (rst_n), .ce_s (b_ce_s), .we_s (b_we_s), .oe_s (b_oe_s),
   .drive (b_drive), .err (b_err), .wr_en (b_wr), .addr (b_addr)
);

// File: tb/mux_dpram_tb.sv
`timescale 1ns/1ps
module mux_dpram_tb;
   localparam int SYNC   = 2;
   localparam int SETTLE = SYNC + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [7:0] pbus [2];
   logic       pce  [2];
   logic       pwe  [2];
   logic       poe  [2];
   logic [7:0] obus [2];
   logic       ooe  [2];
   logic       oerr [2];
   logic [7:0] a_bus_o, b_bus_o;
   logic       a_bus_oe, b_bus_oe, a_err, b_err;

   mux_dpram #(.ADDR_W(8), .SYNC_STAGES(SYNC), .A_WRITE_WINS(1'b1)) u_dut (
      .clk (clk), .rst_n (rst_n),
      .a_bus_i (pbus[0]), .a_ce_n (pce[0]), .a_we_n (pwe[0]), .a_oe_n (poe[0]),
      .a_bus_o (a_bus_o), .a_bus_oe (a_bus_oe), .a_err (a_err),
      .b_bus_i (pbus[1]), .b_ce_n (pce[1]), .b_we_n (pwe[1]), .b_oe_n (poe[1]),
      .b_bus_o (b_bus_o), .b_bus_oe (b_bus_oe), .b_err (b_err)
   );

   assign obus[0] = a_bus_o;  assign obus[1] = b_bus_o;
   assign ooe[0]  = a_bus_oe; assign ooe[1]  = b_bus_oe;
   assign oerr[0] = a_err;    assign oerr[1] = b_err;

   // behavioural reference model
   int   n_chk = 0, n_fail = 0;
   bit   run = 0, done = 0;
   int   settle [2];
   bit   exp_oe [2];
   bit   exp_err [2];
   int   lat [2];
   int   pend [2];
   int   mem_m [int];

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // per-clock comparison, 1 ns after the rising edge
   always @(posedge clk) begin
      #1;
      if (run) begin
         for (int p = 0; p < 2; p++) begin
            if (settle[p] > 0) settle[p]--;
            else begin
               chk(ooe[p] == exp_oe[p], "R3 driver enable", ooe[p], exp_oe[p]);
               chk(oerr[p] == exp_err[p], "R9 error flag", oerr[p], exp_err[p]);
               if (exp_oe[p]) begin
                  chk(mem_m.exists(lat[p]) && obus[p] == mem_m[lat[p]][7:0],
                      "R3 read data", obus[p],
                      mem_m.exists(lat[p]) ? mem_m[lat[p]] : -1);
               end
            end
         end
      end
   end

   task automatic wt();
      repeat (SETTLE + 1) @(negedge clk);
   endtask

   task automatic p_begin(input int p, input logic [7:0] a);
      pbus[p] = a; pce[p] = 1'b0; lat[p] = a;
      exp_oe[p] = 0; exp_err[p] = 0; settle[p] = SETTLE;
   endtask

   task automatic p_read(input int p);
      pbus[p] = 8'hC3; poe[p] = 1'b0;
      exp_oe[p] = 1; settle[p] = SETTLE;
   endtask

   task automatic p_wr_start(input int p, input logic [7:0] d);
      pbus[p] = d; pwe[p] = 1'b0; pend[p] = d; settle[p] = SETTLE;
   endtask

   task automatic p_wr_end(input int p);
      pwe[p] = 1'b1; mem_m[lat[p]] = pend[p]; settle[p] = SETTLE;
      settle[1-p] = SETTLE;
   endtask

   task automatic p_end(input int p);
      pce[p] = 1'b1; pwe[p] = 1'b1; poe[p] = 1'b1;
      exp_oe[p] = 0; exp_err[p] = 0; settle[p] = SETTLE;
   endtask

   task automatic do_write(input int p, input logic [7:0] a, input logic [7:0] d);
      p_begin(p, a); wt();
      p_wr_start(p, d); wt();
      p_wr_end(p); wt();
      p_end(p); wt();
   endtask

   task automatic read_expect(input int p, input logic [7:0] a, input logic [7:0] e,
                              input string tag);
      p_begin(p, a); wt();
      p_read(p); wt();
      chk(ooe[p] && obus[p] == e, tag, obus[p], e);
      p_end(p); wt();
   endtask

   initial begin
      for (int p = 0; p < 2; p++) begin
         pbus[p] = 8'h00; pce[p] = 1'b1; pwe[p] = 1'b1; poe[p] = 1'b1;
         settle[p] = 0; exp_oe[p] = 0; exp_err[p] = 0; lat[p] = 0; pend[p] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk(!a_bus_oe && !b_bus_oe, "R10 drivers off after reset", {a_bus_oe, b_bus_oe}, 0);
      chk(!a_err && !b_err, "R10 no error after reset", {a_err, b_err}, 0);
      run = 1;

      // R1: extremes of the address space through both ports
      do_write(0, 8'h00, 8'hA5);
      do_write(0, 8'hFF, 8'h5A);
      do_write(1, 8'h80, 8'h3C);
      read_expect(1, 8'h00, 8'hA5, "R1 B reads A addr 00");
      read_expect(1, 8'hFF, 8'h5A, "R1 B reads A addr FF");
      read_expect(0, 8'h80, 8'h3C, "R1 A reads B addr 80");

      // R5: write terminated by select rising instead of write strobe
      p_begin(0, 8'h21); wt();
      p_wr_start(0, 8'h9E); wt();
      pce[0] = 1'b1; pwe[0] = 1'b1; mem_m[8'h21] = 8'h9E; settle[0] = SETTLE; wt();
      read_expect(1, 8'h21, 8'h9E, "R5 commit on select rise");

      // R2: bus changes after latching do not move the address
      do_write(1, 8'h22, 8'h44);
      p_begin(0, 8'h22); wt();
      pbus[0] = 8'hFF; wt();
      p_read(0); wt();
      chk(a_bus_oe && a_bus_o == 8'h44, "R2 address held", a_bus_o, 8'h44);
      // R4: read strobe rises, lowering it again without new select gives no drive
      poe[0] = 1'b1; exp_oe[0] = 0; settle[0] = SETTLE; wt();
      chk(!a_bus_oe, "R4 released after strobe rise", a_bus_oe, 0);
      poe[0] = 1'b0; settle[0] = SETTLE; wt();
      chk(!a_bus_oe, "R4 no drive without new select", a_bus_oe, 0);
      p_end(0); wt();

      // R6: simultaneous reads of the same location
      p_begin(0, 8'hFF); p_begin(1, 8'hFF); wt();
      p_read(0); p_read(1); wt();
      chk(a_bus_oe && a_bus_o == 8'h5A, "R6 port A shared read", a_bus_o, 8'h5A);
      chk(b_bus_oe && b_bus_o == 8'h5A, "R6 port B shared read", b_bus_o, 8'h5A);
      p_end(0); p_end(1); wt();

      // R7: colliding writes on the same edge, A wins
      p_begin(0, 8'h50); p_begin(1, 8'h50); wt();
      p_wr_start(0, 8'hAA); p_wr_start(1, 8'hBB); wt();
      pwe[0] = 1'b1; pwe[1] = 1'b1; mem_m[8'h50] = 8'hAA;
      settle[0] = SETTLE; settle[1] = SETTLE; wt();
      p_end(0); p_end(1); wt();
      read_expect(1, 8'h50, 8'hAA, "R7 port A byte kept");

      // R8: read of a location the other port commits
      do_write(0, 8'h40, 8'h11);
      p_begin(0, 8'h40); p_begin(1, 8'h40); wt();
      p_read(1); wt();
      p_wr_start(0, 8'h22); wt();
      settle[1] = 1000;
      pwe[0] = 1'b1; settle[0] = SETTLE;
      repeat (SYNC + 1) @(posedge clk);
      @(negedge clk);
      chk(b_bus_o == 8'h11, "R8 old byte in commit cycle", b_bus_o, 8'h11);
      @(negedge clk);
      chk(b_bus_o == 8'h22, "R8 new byte next cycle", b_bus_o, 8'h22);
      mem_m[8'h40] = 8'h22; settle[1] = 0;
      wt();
      p_end(0); p_end(1); wt();

      // R9: both strobes low flags an error, no drive, no write
      do_write(1, 8'h30, 8'h77);
      p_begin(1, 8'h30); wt();
      pbus[1] = 8'hEE; pwe[1] = 1'b0; poe[1] = 1'b0;
      exp_err[1] = 1; exp_oe[1] = 0; settle[1] = SETTLE; wt();
      chk(b_err && !b_bus_oe, "R9 error raised, no drive", {b_err, b_bus_oe}, 2);
      pwe[1] = 1'b1; settle[1] = SETTLE; wt();
      chk(b_err, "R9 error held while selected", b_err, 1);
      p_end(1); wt();
      chk(!b_err, "R9 error cleared by select rise", b_err, 0);
      read_expect(0, 8'h30, 8'h77, "R9 memory untouched");

      run = 0;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule